// File: doc/BRIEF.md
# Queue-Coupled Three-Stage Increment/Branch Pipeline

This block is a very small synchronous processor split into three stages: instruction fetch, operand read and execute/writeback. Each pair of neighbouring stages shares a single-slot queue. A slot is one holding register plus a presence flag. A stage advances in a cycle only when the slot it feeds will be free by the end of that cycle. Every firing decision uses the register state from the start of the cycle, and all stages commit together at the clock edge.

The machine has two instructions. One adds one to a register. The other jumps to a target location when a register reads zero. A taken jump redirects the program counter and empties both queue slots in the same edge. Operand read stalls while the execute slot holds an instruction that names the same register, so an instruction never reads a stale value. The program is written into instruction memory through a load port, normally while reset is held. The program counter and the whole register file are visible on debug outputs.

Top module: `qpipe_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 0, all eight registers become 0 and both queue slots become empty.
- R2: When the fetch slot is empty, or its entry moves on in the same cycle, fetch loads the word at the program counter into the slot and the program counter advances by one.
- R3: An increment that reaches execute writes (v+1) modulo 256 into its register, where v is the value read during operand read.
- R4: Operand read does not take an instruction while the execute slot holds an entry that names the same register. The instruction is taken in the following cycle and reads the updated value.
- R5: A branch in execute whose operand is zero loads the program counter with its target and empties both slots at the same edge. The two younger instructions in flight have no effect on the register file.
- R6: A branch in execute whose operand is nonzero only leaves the execute slot. Fetch continues sequentially and the following instructions execute.
- R7: When the fetch slot is full and cannot drain, the program counter keeps its value.
- R8: An instruction is 12 bits. Bit 11 is the opcode (0 = increment, 1 = branch-if-zero), bits 10:8 give the register and bits 7:0 give the branch target.
- R9: When `ld_we` is high at a clock edge, `ld_data` is written to instruction memory at `ld_addr`.
- R10: The program counter is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Instruction memory write enable |
| ld_addr | input | 8 | Instruction memory write address |
| ld_data | input | 12 | Instruction word to write |
| pc_o | output | 8 | Current program counter |
| rf_o | output | 64 | Register file; register i is bits [8i+7:8i] |

## Verification
The bound checker verifies four properties on every cycle: sequential program counter advance into an empty fetch slot, the counter holding during a register hazard, the redirect and double flush after a taken branch, and the increment result written by execute. Other behaviour depends on instruction order and so can only be shown by the bench's programs. These cases are the stale read the hazard interlock prevents, a not-taken branch letting later instructions through, counter wrap-around during a long run and the reset values. The bench compares both debug outputs against a behavioural model on every clock.

// File: rtl/qpipe_pkg.sv
package qpipe_pkg;
    parameter int REG_W  = 3;
    parameter int DATA_W = 8;
    parameter int LOC_W  = 8;
    localparam int NREG   = 1 << REG_W;
    localparam int INSN_W = 1 + REG_W + LOC_W;

    typedef enum logic { OP_INC = 1'b0, OP_BRZ = 1'b1 } opc_e;

    typedef struct packed {
        opc_e              op;
        logic [REG_W-1:0]  r;
        logic [LOC_W-1:0]  loc;
    } insn_t;

    typedef struct packed {
        logic [LOC_W-1:0]  pc;
        logic              fq_v;
        insn_t             fq;
        logic              oq_v;
        insn_t             oq;
        logic [DATA_W-1:0] oq_val;
    } pipe_t;
endpackage

// File: rtl/qpipe_imem.sv
module qpipe_imem #(
    parameter int AW = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/qpipe_rf.sv
module qpipe_rf #(
    parameter int RW = 3,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [RW-1:0]         waddr,
    input  logic [DW-1:0]         wdata,
    input  logic [RW-1:0]         raddr,
    output logic [DW-1:0]         rdata,
    output logic [(DW<<RW)-1:0]   flat_o
);
    localparam int N = 1 << RW;

    logic [DW-1:0] rf_d [N];
    logic [DW-1:0] rf_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rf_d[i] = rf_q[i];
        end
        if (we) begin
            rf_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) rf_q[i] <= '0;
            else     rf_q[i] <= rf_d[i];
        end
    end

    assign rdata = rf_q[raddr];

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign flat_o[g*DW +: DW] = rf_q[g];
    end
endmodule

// File: rtl/qpipe_core.sv
module qpipe_core
    import qpipe_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_we,
    input  logic [LOC_W-1:0]         ld_addr,
    input  logic [INSN_W-1:0]        ld_data,
    output logic [LOC_W-1:0]         pc_o,
    output logic [DATA_W*NREG-1:0]   rf_o
);
    pipe_t st_d, st_q;

    logic [INSN_W-1:0] fetch_word;
    logic [DATA_W-1:0] opnd_val;
    logic              fq_v, oq_v;
    logic [REG_W-1:0]  fq_r, oq_r;
    logic [LOC_W-1:0]  oq_loc;
    logic [DATA_W-1:0] oq_val;
    logic              taken, wb_inc, raw_hit, of_fire, fetch_fire;

    assign fq_v   = st_q.fq_v;
    assign oq_v   = st_q.oq_v;
    assign fq_r   = st_q.fq.r;
    assign oq_r   = st_q.oq.r;
    assign oq_loc = st_q.oq.loc;
    assign oq_val = st_q.oq_val;

    // execute decisions from start-of-cycle slot contents
    assign taken   = oq_v && (st_q.oq.op == OP_BRZ) && (oq_val == '0);
    assign wb_inc  = oq_v && (st_q.oq.op == OP_INC);
    // operand read waits while execute holds the same register
    assign raw_hit = oq_v && (oq_r == fq_r);
    assign of_fire = fq_v && !raw_hit && !taken;
    // fetch slot will be free by end of cycle
    assign fetch_fire = !fq_v || taken || of_fire;

    qpipe_imem #(.AW(LOC_W), .DW(INSN_W)) u_imem (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (st_q.pc),
        .rdata (fetch_word)
    );

    qpipe_rf #(.RW(REG_W), .DW(DATA_W)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (wb_inc),
        .waddr  (oq_r),
        .wdata  (oq_val + DATA_W'(1)),
        .raddr  (fq_r),
        .rdata  (opnd_val),
        .flat_o (rf_o)
    );

    always_comb begin
        st_d = st_q;
        // execute always consumes its slot
        if (oq_v) begin
            st_d.oq_v = 1'b0;
        end
        if (of_fire) begin
            st_d.oq_v   = 1'b1;
            st_d.oq     = st_q.fq;
            st_d.oq_val = opnd_val;
            st_d.fq_v   = 1'b0;
        end
        if (fetch_fire) begin
            st_d.fq_v = 1'b1;
            st_d.fq   = insn_t'(fetch_word);
            st_d.pc   = st_q.pc + LOC_W'(1);
        end
        // redirect wins over sequential fetch
        if (taken) begin
            st_d.pc   = oq_loc;
            st_d.fq_v = 1'b0;
            st_d.oq_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc_o = st_q.pc;
endmodule

// File: rtl/qpipe_core_chk.sv
module qpipe_core_chk
    import qpipe_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [LOC_W-1:0]       pc_o,
    input logic [DATA_W*NREG-1:0] rf_o,
    input logic                   fq_v,
    input logic                   oq_v,
    input logic [REG_W-1:0]       fq_r,
    input logic [REG_W-1:0]       oq_r,
    input logic [LOC_W-1:0]       oq_loc,
    input logic [DATA_W-1:0]      oq_val,
    input logic                   taken,
    input logic                   wb_inc
);
    logic              last_inc;
    logic [REG_W-1:0]  last_r;
    logic [DATA_W-1:0] last_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_inc <= 1'b0;
            last_r   <= '0;
            last_v   <= '0;
        end else begin
            last_inc <= wb_inc;
            last_r   <= oq_r;
            last_v   <= oq_val;
        end
    end

    // R2
    fetch_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (!fq_v && !taken) |=> (pc_o == LOC_W'($past(pc_o) + LOC_W'(1))));

    // R4
    hazard_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fq_v && oq_v && (fq_r == oq_r) && !taken) |=> ($stable(pc_o) && fq_v));

    // R5
    redirect_flush_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> (!fq_v && !oq_v && (pc_o == $past(oq_loc))));

    // R3
    inc_result_chk: assert property (@(posedge clk) disable iff (rst)
        last_inc |-> (rf_o[last_r*DATA_W +: DATA_W] == DATA_W'(last_v + DATA_W'(1))));
endmodule

bind qpipe_core qpipe_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc_o   (pc_o),
    .rf_o   (rf_o),
    .fq_v   (fq_v),
    .oq_v   (oq_v),
    .fq_r   (fq_r),
    .oq_r   (oq_r),
    .oq_loc (oq_loc),
    .oq_val (oq_val),
    .taken  (taken),
    .wb_inc (wb_inc)
);

// File: tb/qpipe_core_test.sv
module qpipe_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [11:0] ld_data = '0;
    logic [7:0]  pc_o;
    logic [63:0] rf_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wraps = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qpipe_core uut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .pc_o(pc_o), .rf_o(rf_o)
    );

    // behavioural reference: R8 encoding op=bit11, r=bits10:8, l=bits7:0
    int m_mem [256];
    int m_rf [8];
    int m_pc = 0;
    bit m_fq_full = 0, m_oq_full = 0;
    int m_fq = 0, m_oq = 0, m_oq_val = 0;

    always @(posedge clk) begin
        int fq_r, oq_op, oq_r, oq_l, fetched;
        bit do_exec_jump, do_read, do_fetch;
        started = 1;
        fetched = m_mem[m_pc];
        if (rst) begin
            m_pc = 0; m_fq_full = 0; m_oq_full = 0;
            for (int i = 0; i < 8; i++) m_rf[i] = 0;
        end else begin
            fq_r  = (m_fq >> 8) & 7;
            oq_op = (m_oq >> 11) & 1;
            oq_r  = (m_oq >> 8) & 7;
            oq_l  = m_oq & 255;
            do_exec_jump = m_oq_full && oq_op == 1 && m_oq_val == 0;
            do_read = m_fq_full && !(m_oq_full && oq_r == fq_r) && !do_exec_jump;
            do_fetch = !m_fq_full || do_read || do_exec_jump;
            if (m_oq_full && oq_op == 0) m_rf[oq_r] = (m_oq_val + 1) % 256;
            if (do_exec_jump) begin
                m_pc = oq_l; m_fq_full = 0; m_oq_full = 0;
            end else begin
                m_oq_full = 0;
                if (do_read) begin
                    m_oq = m_fq; m_oq_full = 1;
                    m_oq_val = m_rf[fq_r];
                    if (m_oq_full && oq_op == 0 && oq_r == fq_r) m_oq_val = m_oq_val;
                end
                if (do_fetch) begin
                    m_fq = fetched; m_fq_full = 1; m_pc = (m_pc + 1) % 256;
                end
            end
        end
        if (ld_we) m_mem[ld_addr] = ld_data;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rfv(input int i);
        return rf_o[i*8 +: 8];
    endfunction

    // per-cycle comparison against the model
    logic [7:0] prev_pc = '0;
    bit prev_run = 0;
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 pc vs model", pc_o, m_pc);
            for (int i = 0; i < 8; i++) begin
                if (rfv(i) != m_rf[i]) check("R3 rf vs model", rfv(i), m_rf[i]);
            end
            // R10: wrap observed directly
            if (prev_run && !rst && prev_pc == 8'd255 && pc_o != 8'd255) begin
                wraps++;
                check("R10 pc wrap", pc_o, 0);
            end
            prev_pc = pc_o;
            prev_run = !rst;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [11:0] inc_w(input int r);
        return {1'b0, 3'(r), 8'd0};
    endfunction
    function automatic logic [11:0] brz_w(input int r, input int l);
        return {1'b1, 3'(r), 8'(l)};
    endfunction

    task automatic put(input int a, input logic [11:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 8'(a); ld_data = w;
    endtask

    // R9: program goes in through the load port under reset; default fill INC r6
    task automatic fill_default;
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 256; a++) put(a, inc_w(6));
    endtask

    task automatic start_run;
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        check("R1 reset pc", pc_o, 0);
        check("R1 reset rf", (rf_o == 64'd0) ? 1 : 0, 1);
        rst = 1'b0;
    endtask

    initial begin
        // Scenario A: R2 R3 R8 R9 straight-line increments
        fill_default();
        put(0, inc_w(1)); put(1, inc_w(2)); put(2, inc_w(2));
        put(3, inc_w(3)); put(4, brz_w(7, 4));
        start_run();
        repeat (30) @(negedge clk);
        check("R3 r1", rfv(1), 1);
        check("R3 r2", rfv(2), 2);
        check("R9 r3", rfv(3), 1);
        check("R8 r6 untouched", rfv(6), 0);

        // Scenario B: R5 taken branch flushes younger work
        fill_default();
        put(0, inc_w(1)); put(1, brz_w(0, 5)); put(2, inc_w(2));
        put(3, inc_w(3)); put(4, inc_w(4)); put(5, inc_w(5)); put(6, brz_w(7, 6));
        start_run();
        repeat (30) @(negedge clk);
        check("R5 r1", rfv(1), 1);
        check("R5 r2 flushed", rfv(2), 0);
        check("R5 r3 flushed", rfv(3), 0);
        check("R5 r4 skipped", rfv(4), 0);
        check("R5 r5 target ran", rfv(5), 1);
        check("R5 halt pc", (pc_o >= 8'd6 && pc_o <= 8'd8) ? 1 : 0, 1);

        // Scenario C: R6 not-taken branch, R4 branch waits for r1 update
        fill_default();
        put(0, inc_w(1)); put(1, brz_w(1, 7)); put(2, inc_w(2)); put(3, brz_w(7, 3));
        start_run();
        repeat (30) @(negedge clk);
        check("R6 r1", rfv(1), 1);
        check("R6 r2 ran", rfv(2), 1);
        check("R4 no stale jump", rfv(6), 0);

        // Scenario E: R4 R7 back-to-back same-register increments, exact pc trace
        fill_default();
        put(0, inc_w(1)); put(1, inc_w(1)); put(2, inc_w(1)); put(3, brz_w(7, 3));
        start_run();
        @(negedge clk); check("R2 pc e1", pc_o, 1);
        @(negedge clk); check("R2 pc e2", pc_o, 2);
        @(negedge clk); check("R7 pc held e3", pc_o, 2);
        check("R3 r1 e3", rfv(1), 1);
        @(negedge clk); check("R4 pc e4", pc_o, 3);
        @(negedge clk); check("R7 pc held e5", pc_o, 3);
        check("R4 r1 e5", rfv(1), 2);
        @(negedge clk); check("R2 pc e6", pc_o, 4);
        @(negedge clk); check("R2 pc e7", pc_o, 5);
        check("R4 r1 e7", rfv(1), 3);
        @(negedge clk); check("R5 pc e8", pc_o, 3);

        // Scenario D: R10 wrap and R3 modulo-256 increment
        fill_default();
        start_run();
        repeat (600) @(negedge clk);
        check("R3 r6 wrapped count", rfv(6), 43);
        check("R10 wrap seen", (wraps > 0) ? 1 : 0, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule